// File: doc/BRIEF.md
# Vector-Length Control Register Access Arbiter

This block decides, in one combinational pass, what happens when software issues a system-register read or write that names one of the two vector-length control registers. One is the hypervisor-level register. The other is a lower-level alias whose physical target changes with the machine state. The block first compares the decoded five-field register encoding against both registers. It then applies the trap and enable controls of privilege levels 1, 2 and 3 in a fixed, level-specific priority order. The result is exactly one of three outcomes: undefined instruction, trap (with a target level and a 6-bit exception class), or permitted access.

When the access is permitted, the block reports which physical storage is touched: the level-1 register, the level-2 register, or a slot in nested-virtualization memory. It also reports the transfer direction, so the register file or memory port can act on it. Reads and writes follow the same check order. The direction bit only passes through to the target side. Raising the exception and holding the register contents belong to neighbouring logic.

Top module: `vl_access_arbiter`

## Requirements
- R1: An encoding other than {3, 4, 1, 2, 0} (hypervisor register) or {3, 0, 1, 2, 0} (lower alias), listed as fields A..E, sets `no_match` to 1 and drives `outcome`, `trap_lvl`, `exc_class`, `target_sel` and `target_write` to zero. A matching encoding clears `no_match`.
- R2: Any matching access from level 0 gives undefined. `outcome` is a one-hot 3-bit vector: bit 0 means undefined, bit 1 means trap, bit 2 means access.
- R3: A level-1 access to the hypervisor encoding traps to level 2 with class 0x18 when `nest_ctl[0]` is 1. When that bit is 0, the access is undefined.
- R4: For level-2 accesses to either encoding, and for level-1 accesses to the alias, the highest-priority check is undefined-priority: `top_present`, `undef_prio` and `l3_gate`==0 together give undefined.
- R5: At level 2 the second check is: not in host mode with `l2_nonhost_trap` set traps to level 2 with class 0x19. The third check is: in host mode with `l2_gate_lo` clear traps to level 2 with class 0x19.
- R6: The final check is `top_present` with `l3_gate` clear. It gives undefined when `dbg_undef` is 1, otherwise a trap to level 3 with class 0x19. Otherwise the access proceeds.
- R7: At level 3, `l3_gate` clear traps to level 3 with class 0x19. Otherwise the access proceeds, with no other control consulted.
- R8: For the alias at level 1, `l1_gate_lo` clear traps to level 1 with class 0x19. This check ranks below the R4 check and above the level-2 checks. The non-host trap check of R5 applies only when `l2_active` is 1.
- R9: A permitted level-1 alias access with `nest_ctl`==3'b111 selects the memory slot (`target_sel`=3). Any other permitted level-1 alias access selects the level-1 register (`target_sel`=1).
- R10: The hypervisor encoding always selects the level-2 register (`target_sel`=2). The alias at level 2 selects the level-2 register in host mode and the level-1 register otherwise. The alias at level 3 selects the level-1 register.
- R11: `trap_lvl` and `exc_class` are zero unless the outcome is trap. `target_sel` is zero and `target_write` is 0 unless the outcome is access. On access, `target_write` equals `acc_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_write | input | 1 | Access direction, 1 = write |
| enc_a | input | 2 | Encoding field A |
| enc_b | input | 3 | Encoding field B (4 = hypervisor, 0 = alias) |
| enc_c | input | 4 | Encoding field C |
| enc_d | input | 4 | Encoding field D |
| enc_e | input | 3 | Encoding field E |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| host_mode | input | 1 | Level 2 is running as host |
| nest_ctl | input | 3 | Nested-virtualization control bits |
| l1_gate_lo | input | 1 | Low bit of the level-1 vector enable field |
| l2_nonhost_trap | input | 1 | Level-2 vector trap bit (non-host mode) |
| l2_gate_lo | input | 1 | Low bit of the level-2 vector enable field (host mode) |
| l3_gate | input | 1 | Level-3 vector enable bit |
| top_present | input | 1 | Level 3 is implemented |
| undef_prio | input | 1 | Secure-debug undefined takes priority over traps |
| dbg_undef | input | 1 | Secure-debug undefined condition holds |
| l2_active | input | 1 | Level 2 is enabled in the current security state |
| no_match | output | 1 | Encoding names neither register |
| outcome | output | 3 | One-hot {access, trap, undefined} |
| trap_lvl | output | 2 | Trap target level |
| exc_class | output | 6 | Trap exception class |
| target_sel | output | 2 | 0 none, 1 level-1 register, 2 level-2 register, 3 memory slot |
| target_write | output | 1 | Direction forwarded to the selected target |

## Verification
The hardest situations to reach are the ones where several checks would fire at once and only the ranking decides the result. Examples are the level-1 enable check competing with the level-3 undefined-priority check, or a non-host trap that must be ignored because level 2 is disabled. Random stimulus seldom lines these up. The bench therefore sweeps every combination of the control inputs, both encodings, all four levels and both directions. Each vector is compared against an arithmetic model of the ranked checks, so every pairing of competing conditions occurs. A separate sweep walks the full encoding space with the controls fixed.

// File: rtl/vl_access_pkg.sv
package vl_access_pkg;
    localparam int LVL_W = 2;
    localparam int EC_W  = 6;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LOW  = 2'd1,
        TGT_HIGH = 2'd2,
        TGT_SLOT = 2'd3
    } target_e;

    typedef struct packed {
        logic             undef;
        logic             trap;
        logic [LVL_W-1:0] lvl;
        logic [EC_W-1:0]  ec;
    } verdict_t;
endpackage

// File: rtl/vl_enc_match.sv
module vl_enc_match #(
    parameter logic [1:0] F_A      = 2'd3,
    parameter logic [2:0] F_B_HIGH = 3'd4,
    parameter logic [2:0] F_B_LOW  = 3'd0,
    parameter logic [3:0] F_C      = 4'd1,
    parameter logic [3:0] F_D      = 4'd2,
    parameter logic [2:0] F_E      = 3'd0
) (
    input  logic [1:0] enc_a,
    input  logic [2:0] enc_b,
    input  logic [3:0] enc_c,
    input  logic [3:0] enc_d,
    input  logic [2:0] enc_e,
    output logic       hit_high,
    output logic       hit_low
);
    logic common;

    always_comb begin
        common   = (enc_a == F_A) && (enc_c == F_C) && (enc_d == F_D) && (enc_e == F_E);
        hit_high = common && (enc_b == F_B_HIGH);
        hit_low  = common && (enc_b == F_B_LOW);
    end
endmodule

// File: rtl/vl_guard_chain.sv
module vl_guard_chain
    import vl_access_pkg::*;
#(
    parameter logic [EC_W-1:0] EC_VEC = 6'h19
) (
    input  logic     use_l1_gate,
    input  logic     l1_gate_lo,
    input  logic     apply_nonhost,
    input  logic     host_mode,
    input  logic     nonhost_trap,
    input  logic     l2_gate_lo,
    input  logic     top_present,
    input  logic     undef_prio,
    input  logic     l3_gate,
    input  logic     dbg_undef,
    output verdict_t verdict
);
    always_comb begin
        verdict = '0;
        if (top_present && undef_prio && !l3_gate) begin
            verdict.undef = 1'b1;
        end else if (use_l1_gate && !l1_gate_lo) begin
            verdict.trap = 1'b1;
            verdict.lvl  = 2'd1;
            verdict.ec   = EC_VEC;
        end else if (apply_nonhost && !host_mode && nonhost_trap) begin
            verdict.trap = 1'b1;
            verdict.lvl  = 2'd2;
            verdict.ec   = EC_VEC;
        end else if (host_mode && !l2_gate_lo) begin
            verdict.trap = 1'b1;
            verdict.lvl  = 2'd2;
            verdict.ec   = EC_VEC;
        end else if (top_present && !l3_gate) begin
            if (dbg_undef) begin
                verdict.undef = 1'b1;
            end else begin
                verdict.trap = 1'b1;
                verdict.lvl  = 2'd3;
                verdict.ec   = EC_VEC;
            end
        end
    end
endmodule

// File: rtl/vl_target_pick.sv
module vl_target_pick
    import vl_access_pkg::*;
(
    input  logic       hit_high,
    input  logic [1:0] cur_lvl,
    input  logic       host_mode,
    input  logic [2:0] nest_ctl,
    output target_e    target
);
    always_comb begin
        target = TGT_LOW;
        if (hit_high) begin
            target = TGT_HIGH;
        end else begin
            unique case (cur_lvl)
                2'd1:    target = (&nest_ctl) ? TGT_SLOT : TGT_LOW;
                2'd2:    target = host_mode ? TGT_HIGH : TGT_LOW;
                default: target = TGT_LOW;
            endcase
        end
    end
endmodule

// File: rtl/vl_access_arbiter.sv
module vl_access_arbiter
    import vl_access_pkg::*;
#(
    parameter logic [EC_W-1:0] EC_NESTED = 6'h18,
    parameter logic [EC_W-1:0] EC_VEC    = 6'h19
) (
    input  logic             acc_write,
    input  logic [1:0]       enc_a,
    input  logic [2:0]       enc_b,
    input  logic [3:0]       enc_c,
    input  logic [3:0]       enc_d,
    input  logic [2:0]       enc_e,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             host_mode,
    input  logic [2:0]       nest_ctl,
    input  logic             l1_gate_lo,
    input  logic             l2_nonhost_trap,
    input  logic             l2_gate_lo,
    input  logic             l3_gate,
    input  logic             top_present,
    input  logic             undef_prio,
    input  logic             dbg_undef,
    input  logic             l2_active,
    output logic             no_match,
    output logic [2:0]       outcome,
    output logic [LVL_W-1:0] trap_lvl,
    output logic [EC_W-1:0]  exc_class,
    output logic [1:0]       target_sel,
    output logic             target_write
);
    logic     hit_high, hit_low;
    verdict_t chain_v;
    target_e  picked;
    logic     from_l1;

    assign from_l1 = (cur_lvl == 2'd1);

    vl_enc_match u_match (
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .enc_c    (enc_c),
        .enc_d    (enc_d),
        .enc_e    (enc_e),
        .hit_high (hit_high),
        .hit_low  (hit_low)
    );

    vl_guard_chain #(.EC_VEC(EC_VEC)) u_chain (
        .use_l1_gate   (from_l1),
        .l1_gate_lo    (l1_gate_lo),
        .apply_nonhost (from_l1 ? l2_active : 1'b1),
        .host_mode     (host_mode),
        .nonhost_trap  (l2_nonhost_trap),
        .l2_gate_lo    (l2_gate_lo),
        .top_present   (top_present),
        .undef_prio    (undef_prio),
        .l3_gate       (l3_gate),
        .dbg_undef     (dbg_undef),
        .verdict       (chain_v)
    );

    vl_target_pick u_pick (
        .hit_high  (hit_high),
        .cur_lvl   (cur_lvl),
        .host_mode (host_mode),
        .nest_ctl  (nest_ctl),
        .target    (picked)
    );

    verdict_t fin;
    logic     grant;

    always_comb begin
        fin   = '0;
        grant = 1'b0;
        if (hit_high || hit_low) begin
            unique case (cur_lvl)
                2'd0: fin.undef = 1'b1;
                2'd1: begin
                    if (hit_high) begin
                        if (nest_ctl[0]) begin
                            fin.trap = 1'b1;
                            fin.lvl  = 2'd2;
                            fin.ec   = EC_NESTED;
                        end else begin
                            fin.undef = 1'b1;
                        end
                    end else begin
                        fin   = chain_v;
                        grant = !chain_v.undef && !chain_v.trap;
                    end
                end
                2'd2: begin
                    fin   = chain_v;
                    grant = !chain_v.undef && !chain_v.trap;
                end
                default: begin
                    if (!l3_gate) begin
                        fin.trap = 1'b1;
                        fin.lvl  = 2'd3;
                        fin.ec   = EC_VEC;
                    end else begin
                        grant = 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        no_match     = !(hit_high || hit_low);
        outcome      = {grant, fin.trap, fin.undef};
        trap_lvl     = fin.trap ? fin.lvl : '0;
        exc_class    = fin.trap ? fin.ec : '0;
        target_sel   = grant ? picked : TGT_NONE;
        target_write = grant && acc_write;
    end
endmodule

// File: rtl/vl_access_arbiter_chk.sv
module vl_access_arbiter_chk (
    input logic [2:0] enc_b,
    input logic [1:0] cur_lvl,
    input logic [2:0] nest_ctl,
    input logic       l3_gate,
    input logic       acc_write,
    input logic       no_match,
    input logic [2:0] outcome,
    input logic [1:0] trap_lvl,
    input logic [5:0] exc_class,
    input logic [1:0] target_sel,
    input logic       target_write
);
    always_comb begin
        assert_outcome_shape_R11: assert (no_match ? (outcome == 3'b000) : $onehot(outcome))
            else $error("outcome not one-hot");
        assert_trap_fields_R11: assert (outcome[1] || (trap_lvl == 2'd0 && exc_class == 6'd0))
            else $error("trap fields set without trap");
        assert_target_idle_R11: assert (outcome[2] || (target_sel == 2'd0 && !target_write))
            else $error("target active without access");
        assert_dir_forward_R11: assert (!outcome[2] || (target_write == acc_write))
            else $error("direction not forwarded");
        assert_level0_undef_R2: assert (no_match || cur_lvl != 2'd0 || outcome == 3'b001)
            else $error("level 0 access not undefined");
        assert_level3_R7: assert (no_match || cur_lvl != 2'd3 ||
                (l3_gate ? outcome == 3'b100 : (outcome == 3'b010 && trap_lvl == 2'd3 && exc_class == 6'h19)))
            else $error("level 3 outcome wrong");
        assert_nested_class_R3: assert (exc_class != 6'h18 || (cur_lvl == 2'd1 && trap_lvl == 2'd2 && enc_b == 3'd4))
            else $error("class 0x18 from wrong context");
        assert_slot_only_R9: assert (target_sel != 2'd3 || (cur_lvl == 2'd1 && nest_ctl == 3'b111 && enc_b == 3'd0))
            else $error("memory slot from wrong context");
        assert_high_target_R10: assert (no_match || !outcome[2] || enc_b != 3'd4 || target_sel == 2'd2)
            else $error("hypervisor encoding misrouted");
    end
endmodule

bind vl_access_arbiter vl_access_arbiter_chk u_chk (.*);

// File: tb/test_vl_access_arbiter.sv
module test_vl_access_arbiter;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       acc_write;
    logic [1:0] enc_a;
    logic [2:0] enc_b;
    logic [3:0] enc_c, enc_d;
    logic [2:0] enc_e;
    logic [1:0] cur_lvl;
    logic       host_mode;
    logic [2:0] nest_ctl;
    logic       l1_gate_lo, l2_nonhost_trap, l2_gate_lo, l3_gate;
    logic       top_present, undef_prio, dbg_undef, l2_active;
    logic       no_match, target_write;
    logic [2:0] outcome;
    logic [1:0] trap_lvl, target_sel;
    logic [5:0] exc_class;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    vl_access_arbiter i_vl_access_arbiter (.*);

    // Expected packed as {no_match, outcome[2:0], trap_lvl[1:0], exc_class[5:0], target_sel[1:0], target_write}
    function automatic logic [14:0] pack(input logic nm, input logic [2:0] oc, input logic [1:0] tl,
                                         input logic [5:0] ec, input logic [1:0] ts, input logic tw);
        return {nm, oc, tl, ec, ts, tw};
    endfunction

    task automatic model(output logic [14:0] exp, output string tag);
        logic hi, lo;
        int   kind; // 0 undef, 1 trap, 2 access
        int   tl, ec, ts;
        hi = (enc_a == 2'd3 && enc_b == 3'd4 && enc_c == 4'd1 && enc_d == 4'd2 && enc_e == 3'd0);
        lo = (enc_a == 2'd3 && enc_b == 3'd0 && enc_c == 4'd1 && enc_d == 4'd2 && enc_e == 3'd0);
        kind = 0; tl = 0; ec = 0; ts = 0;
        if (!hi && !lo) begin
            exp = pack(1'b1, 3'b000, 2'd0, 6'd0, 2'd0, 1'b0);
            tag = "R1";
            return;
        end
        if (cur_lvl == 0) begin
            kind = 0; tag = "R2";
        end else if (cur_lvl == 1 && hi) begin
            tag = "R3";
            if (nest_ctl[0]) begin kind = 1; tl = 2; ec = 'h18; end
            else kind = 0;
        end else if (cur_lvl == 3) begin
            tag = "R7";
            if (!l3_gate) begin kind = 1; tl = 3; ec = 'h19; end
            else kind = 2;
        end else begin
            if (top_present && undef_prio && !l3_gate) begin kind = 0; tag = "R4"; end
            else if (cur_lvl == 1 && !l1_gate_lo) begin kind = 1; tl = 1; ec = 'h19; tag = "R8"; end
            else if ((cur_lvl == 2 || l2_active) && !host_mode && l2_nonhost_trap) begin
                kind = 1; tl = 2; ec = 'h19; tag = (cur_lvl == 1) ? "R8" : "R5";
            end
            else if (host_mode && !l2_gate_lo) begin kind = 1; tl = 2; ec = 'h19; tag = "R5"; end
            else if (top_present && !l3_gate) begin
                tag = "R6";
                if (dbg_undef) kind = 0;
                else begin kind = 1; tl = 3; ec = 'h19; end
            end else begin
                kind = 2; tag = "R6";
            end
        end
        if (kind == 2) begin
            if (hi) ts = 2;
            else if (cur_lvl == 1) begin ts = (nest_ctl == 3'b111) ? 3 : 1; tag = "R9"; end
            else if (cur_lvl == 2) begin ts = host_mode ? 2 : 1; tag = "R10"; end
            else begin ts = 1; tag = "R10"; end
        end
        exp = pack(1'b0, (kind == 2) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001,
                   2'(tl), 6'(ec), 2'(ts), (kind == 2) && acc_write);
    endtask

    task automatic compare(input string extra);
        logic [14:0] exp, act;
        string tag;
        model(exp, tag);
        act = {no_match, outcome, trap_lvl, exc_class, target_sel, target_write};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (R11 fields) %s: actual=%h expected=%h lvl=%0d", tag, extra, act, exp, cur_lvl);
        end
    endtask

    initial begin
        // idle state: all inputs zero
        {acc_write, enc_a, enc_b, enc_c, enc_d, enc_e, cur_lvl, host_mode, nest_ctl} = '0;
        {l1_gate_lo, l2_nonhost_trap, l2_gate_lo, l3_gate, top_present, undef_prio, dbg_undef, l2_active} = '0;
        #3;
        compare("R1 idle inputs");

        // exhaustive sweep over controls, both matching encodings, both directions
        for (int v = 0; v < (1 << 17); v++) begin
            logic [16:0] b;
            b = 17'(v);
            enc_a = 2'd3; enc_c = 4'd1; enc_d = 4'd2; enc_e = 3'd0;
            enc_b           = b[0] ? 3'd4 : 3'd0;
            acc_write       = b[1];
            cur_lvl         = b[3:2];
            host_mode       = b[4];
            nest_ctl        = b[7:5];
            l1_gate_lo      = b[8];
            l2_nonhost_trap = b[9];
            l2_gate_lo      = b[10];
            l3_gate         = b[11];
            top_present     = b[12];
            undef_prio      = b[13];
            dbg_undef       = b[14];
            l2_active       = b[15];
            if (b[16]) continue;
            #1;
            compare("sweep");
        end

        // full encoding space with permissive controls at level 2 and level 3
        {host_mode, l1_gate_lo, l2_nonhost_trap, l2_gate_lo, l3_gate, top_present, undef_prio, dbg_undef, l2_active}
            = 9'b0_1_0_1_1_1_0_0_1;
        acc_write = 1'b1;
        nest_ctl  = 3'b000;
        for (int e = 0; e < (1 << 16); e++) begin
            logic [15:0] f;
            f = 16'(e);
            {enc_a, enc_b, enc_c, enc_d, enc_e} = f;
            cur_lvl = f[0] ? 2'd3 : 2'd2;
            #1;
            compare("R1 encoding walk");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule